// File: doc/BRIEF.md
# Atomic Set/Clear Output Port

This block is a memory-mapped 16-bit general-purpose output port with a sampled input view. A simple 32-bit register bus carries an address, a write enable, byte strobes, write data and read data. Software reads and writes the output latch directly. It reads the pin values through a read-only capture register.

The block also offers a write-only 32-bit command word. In that word the low half raises output bits and the high half lowers them. Any mix of bits can be changed in one bus access, with no read-modify-write. If one write both raises and lowers the same bit, the raise wins. A command acts only once and locks nothing, so later direct writes to the latch still take effect.

Top module: `bitop_port`

## Requirements
- R1: After a synchronous active-high reset, the output latch and the `port_out` pins are 0x0000.
- R2: A write to offset 0x14 updates the output latch at the next clock edge. Byte strobe 0 gates bits 7:0 and byte strobe 1 gates bits 15:8. Strobes 2 and 3 have no effect. A read of 0x14 returns the latch in bits 15:0, with zeros in bits 31:16.
- R3: A write to offset 0x18 with data bit i (0..15) at 1 forces output bit i to 1 at the next clock edge.
- R4: A write to offset 0x18 with data bit i+16 at 1 forces output bit i to 0 at the next clock edge.
- R5: Output bits whose raise and lower bits are both 0 in a 0x18 write keep their value.
- R6: When a 0x18 write has both bit i and bit i+16 at 1, output bit i becomes 1.
- R7: A read of offset 0x18 returns 0.
- R8: A 0x18 command does not lock any bit. A later write to 0x14 sets the latch to the new data.
- R9: A read of offset 0x10 returns the `port_in` pins in bits 15:0, as they were two clock edges earlier, with zeros in bits 31:16.
- R10: Reads of any other offset return 0, and writes to any other offset leave the output latch unchanged.
- R11: For a 0x18 write, byte strobes 0 and 1 gate the raise bits 7:0 and 15:8. Byte strobes 2 and 3 gate the lower bits 7:0 and 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| port_in | input | 16 | Asynchronous pin inputs |
| port_out | output | 16 | Output latch driving the pins |

## Verification
The bench targets a raise and a lower aimed at the same bit. A design that gave the lower priority would drive 0 there. It mixes 0x18 commands with zero bits to catch a design that clears untouched outputs. It follows a command with a direct latch write to expose any sticky or locking behaviour. It reads 0x18 back to catch leakage of the last command. It checks the pin view exactly two edges after a change. A design with the wrong synchroniser depth would show the old or new value one cycle off. Partial byte strobes on both write paths catch a design that ignores the strobes or maps them to the wrong half.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    localparam int WIDTH  = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int BE_W   = BUS_W / 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFF_PINS = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_LATCH = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h18;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PINS  = 2'd1,
        SEL_LATCH = 2'd2,
        SEL_CMD   = 2'd3
    } sel_e;

    typedef struct packed {
        logic             load;
        logic [WIDTH-1:0] load_mask;
        logic [WIDTH-1:0] load_data;
        logic [WIDTH-1:0] raise;
        logic [WIDTH-1:0] lower;
    } upd_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_PINS:  return SEL_PINS;
            OFF_LATCH: return SEL_LATCH;
            OFF_CMD:   return SEL_CMD;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WIDTH-1:0] expand_be(input logic [1:0] be);
        logic [WIDTH-1:0] m;
        for (int i = 0; i < WIDTH; i++) m[i] = be[i/8];
        return m;
    endfunction
endpackage

// File: rtl/bitop_sync.sv
module bitop_sync #(
    parameter int W = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else if (g == 0) stage[g] <= d;
                else stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate
    assign q = stage[STAGES-1];
endmodule

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [BUS_W-1:0]  wdata,
    output sel_e              sel,
    output upd_t              upd
);
    always_comb begin
        sel = decode(addr);
        upd = '0;
        if (we) begin
            unique case (sel)
                SEL_LATCH: begin
                    upd.load      = 1'b1;
                    upd.load_mask = expand_be(be[1:0]);
                    upd.load_data = wdata[WIDTH-1:0];
                end
                SEL_CMD: begin
                    upd.raise = wdata[WIDTH-1:0] & expand_be(be[1:0]);
                    upd.lower = wdata[BUS_W-1:WIDTH] & expand_be(be[3:2]);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bitop_latch.sv
module bitop_latch
    import bitop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  upd_t             upd,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            always_comb begin
                if (upd.raise[g])        nxt[g] = 1'b1;
                else if (upd.lower[g])   nxt[g] = 1'b0;
                else if (upd.load && upd.load_mask[g]) nxt[g] = upd.load_data[g];
                else                     nxt[g] = q[g];
            end
        end
    endgenerate
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/bitop_port.sv
module bitop_port
    import bitop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  port_in,
    output logic [WIDTH-1:0]  port_out
);
    sel_e             sel;
    upd_t             upd;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pins_q;

    bitop_decode u_dec (
        .addr(bus_addr), .we(bus_we), .be(bus_be), .wdata(bus_wdata),
        .sel(sel), .upd(upd)
    );

    bitop_latch u_lat (.clk(clk), .rst(rst), .upd(upd), .q(latch_q));

    bitop_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(port_in), .q(pins_q)
    );

    always_comb begin
        unique case (sel)
            SEL_PINS:  bus_rdata = {{(BUS_W-WIDTH){1'b0}}, pins_q};
            SEL_LATCH: bus_rdata = {{(BUS_W-WIDTH){1'b0}}, latch_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign port_out = latch_q;
endmodule

// File: rtl/bitop_port_chk.sv
module bitop_port_chk
    import bitop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BE_W-1:0]   bus_be,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  port_in,
    input logic [WIDTH-1:0]  port_out
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> port_out == '0);

    p_raise_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CMD && bus_be == 4'hF) |=>
            ((port_out & $past(bus_wdata[WIDTH-1:0])) == $past(bus_wdata[WIDTH-1:0])));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CMD && bus_be == 4'hF) |=>
            (((port_out ^ $past(port_out)) &
              ~($past(bus_wdata[WIDTH-1:0]) | $past(bus_wdata[BUS_W-1:WIDTH]))) == '0));

    p_lower_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CMD && bus_be == 4'hF) |=>
            ((port_out & $past(bus_wdata[BUS_W-1:WIDTH]) & ~$past(bus_wdata[WIDTH-1:0])) == '0));

    p_cmd_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_CMD) |-> bus_rdata == '0);

    p_other_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && bus_addr != OFF_CMD && bus_addr != OFF_LATCH) |=> $stable(port_out));

    p_latch_read_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_LATCH) |-> bus_rdata == {16'h0, port_out});
endmodule

bind bitop_port bitop_port_chk u_chk (.*);

// File: tb/bitop_port_test.sv
`timescale 1ns/1ps
module bitop_port_test;
    logic        clk = 0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] port_in;
    logic [15:0] port_out;

    int checks = 0;
    int fails = 0;
    logic [15:0] model;

    always #2 clk = ~clk;

    bitop_port uut (.*);

    typedef struct packed {
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h14, 4'hF, 32'h0000_A5C3},
        '{8'h18, 4'hF, 32'h0000_0004},
        '{8'h18, 4'hF, 32'h0081_0000},
        '{8'h18, 4'hF, 32'h0F0F_0F00},
        '{8'h18, 4'hF, 32'hFFFF_FFFF},
        '{8'h18, 4'hF, 32'hFFFF_0000},
        '{8'h14, 4'h1, 32'hFFFF_12AB},
        '{8'h14, 4'h2, 32'h0000_CD00},
        '{8'h18, 4'h5, 32'h00F0_F00F},
        '{8'h20, 4'hF, 32'hFFFF_FFFF}
    };

    function automatic logic [15:0] apply(input logic [15:0] cur, input vec_t v);
        logic [15:0] r, s, c, m;
        r = cur;
        if (v.addr == 8'h14) begin
            m = {{8{v.be[1]}}, {8{v.be[0]}}};
            r = (cur & ~m) | (v.data[15:0] & m);
        end else if (v.addr == 8'h18) begin
            s = v.data[15:0]  & {{8{v.be[1]}}, {8{v.be[0]}}};
            c = v.data[31:16] & {{8{v.be[3]}}, {8{v.be[2]}}};
            r = (cur & ~c) | s;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        #1 d = bus_rdata;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst = 1; bus_addr = 0; bus_we = 0; bus_be = 0; bus_wdata = 0; port_in = 16'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset out", {16'h0, port_out}, 32'h0);
        rd(8'h14, r); check("R1 reset read", r, 32'h0);

        model = 16'h0;
        // R2 R3 R4 R5 R6 R11 R10 via vector table
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].be, VECS[i].data);
            model = apply(model, VECS[i]);
            check($sformatf("R2/R3/R4/R5/R6/R11/R10 vec %0d", i), {16'h0, port_out}, {16'h0, model});
        end

        // R6 same-bit conflict explicit
        wr(8'h14, 4'hF, 32'h0);
        wr(8'h18, 4'hF, 32'h0008_0008);
        check("R6 raise beats lower", {16'h0, port_out}, 32'h0008);

        // R7 command readback
        rd(8'h18, r); check("R7 cmd reads zero", r, 32'h0);

        // R8 no lock after command
        wr(8'h18, 4'hF, 32'h0000_FFFF);
        wr(8'h14, 4'hF, 32'h0000_1234);
        check("R8 direct write after cmd", {16'h0, port_out}, 32'h1234);
        rd(8'h14, r); check("R2 latch readback", r, 32'h1234);

        // R10 other address
        wr(8'h1C, 4'hF, 32'hFFFF_FFFF);
        check("R10 stray write", {16'h0, port_out}, 32'h1234);
        rd(8'h1C, r); check("R10 stray read", r, 32'h0);

        // R9 two-edge synchroniser
        @(negedge clk); bus_addr = 8'h10; port_in = 16'hBEEF;
        @(negedge clk); #1 check("R9 one edge old", bus_rdata, 32'h0);
        @(negedge clk); #1 check("R9 two edges new", bus_rdata, 32'hBEEF);
        rd(8'h10, r); check("R9 held", r, 32'hBEEF);

        // R1 reset again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R1 second reset", {16'h0, port_out}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule